// File: doc/BRIEF.md
# DMA chunked address sequencer

This block produces the byte address pair (source and destination) for every beat of a memory-to-memory copy. Software supplies a 64-bit start address for each side, a total byte count, a chunk byte count, a beat width code and an increment mode for each side, then pulses a start strobe. The block checks the configuration. If it is valid, the block presents the first address pair at once and steps to the next pair each time the bus side reports a beat as accepted.

Each side picks its own stepping rule. In hold mode the address stays at the start address. In chunk-wrap mode the address returns to the start address whenever a new chunk begins. In run mode the address climbs by the beat width without limit. The total need not be a whole number of chunks, so the last chunk may be cut short. A one-cycle done pulse marks the final accepted beat. A bad configuration gives a one-cycle error pulse, and no transfer starts.

Top module: `dma_addr_seq`

## Requirements
- R1: Mode codes are 0 hold, 1 chunk-wrap, 2 run. Code 3 on either side is invalid, as are width code 3, a zero total and a zero chunk size. A start with any of these raises `cfg_err_o` for exactly one cycle, in the cycle after the start, and `busy_o` stays low.
- R2: In the cycle after a valid start, `busy_o` is high and both address outputs equal their programmed start addresses, whatever the modes.
- R3: In hold mode an address output equals its start address on every beat of the transfer.
- R4: In chunk-wrap mode, the address of a beat whose offset within the chunk is zero equals the start address. Every other beat gets the previous address plus the beat width.
- R5: In run mode, each beat after the first gets the previous address plus the beat width, with carry across the full 64 bits.
- R6: Source and destination each follow their own mode and start address; neither affects the other.
- R7: Width code 0, 1 and 2 give 1, 2 and 4 bytes per beat. Both the chunk offset and the total count advance by that amount on each accepted beat.
- R8: The chunk offset restarts at zero when it reaches the chunk size, so a short final chunk is allowed. On the accepted beat that brings the total to the programmed count, `done_o` is high for exactly one cycle and `busy_o` falls in that same cycle.
- R9: A cycle without an accepted beat leaves both addresses unchanged. `beat_ok_i` while idle has no effect.
- R10: `start_i` while busy is ignored: it neither restarts the transfer nor raises `cfg_err_o`.
- R11: After reset, `busy_o`, `done_o` and `cfg_err_o` are low and both addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; the configuration is sampled when it is accepted |
| src_start_i | input | AW | Source start byte address |
| dst_start_i | input | AW | Destination start byte address |
| total_bytes_i | input | CW | Total bytes to move |
| chunk_bytes_i | input | CW | Bytes per chunk |
| width_code_i | input | 2 | Beat width code (0:1, 1:2, 2:4 bytes) |
| src_mode_i | input | 2 | Source increment mode |
| dst_mode_i | input | 2 | Destination increment mode |
| beat_ok_i | input | 1 | Current beat accepted by the bus side |
| busy_o | output | 1 | Transfer in progress |
| src_addr_o | output | AW | Source address of the current beat |
| dst_addr_o | output | AW | Destination address of the current beat |
| done_o | output | 1 | One-cycle pulse after the final beat |
| cfg_err_o | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
The hardest case to reach from the ports is a chunk-wrap side in a transfer whose total is not a whole number of chunks. The wrap and the final beat then fall on different chunk offsets, and an off-by-one in the rollover compare only shows up in the short tail. Table vectors therefore pair a wrapping side with totals of 2.5 and 2.5 chunks at widths of 1 and 4 bytes. Another vector starts a run-mode side four bytes below a 32-bit boundary to expose a lost carry. Stalled beats and start strobes issued mid-transfer with a junk configuration run inside the same walks.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD       = 2'd0,
    MODE_CHUNK_WRAP = 2'd1,
    MODE_RUN        = 2'd2
  } step_mode_e;

  localparam int STEP_W = 3;

  // Beat width code to bytes; the unused code yields zero.
  function automatic logic [STEP_W-1:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic mode_valid(input logic [1:0] m);
    return (m == MODE_HOLD) || (m == MODE_CHUNK_WRAP) || (m == MODE_RUN);
  endfunction

endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check
  import dma_seq_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [1:0]    width_code_i,
  input  logic [CW-1:0] total_i,
  input  logic [CW-1:0] chunk_i,
  output logic          mode_bad_o,
  output logic          size_bad_o
);

  always_comb begin
    mode_bad_o = !mode_valid(src_mode_i) || !mode_valid(dst_mode_i);
    size_bad_o = (beat_bytes(width_code_i) == '0) || (total_i == '0) || (chunk_i == '0);
  end

endmodule

// File: rtl/seq_byte_counter.sv
module seq_byte_counter
  import dma_seq_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              fire_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CW-1:0]     total_i,
  input  logic [CW-1:0]     chunk_i,
  output logic              rollover_o,
  output logic              last_o
);

  localparam int NW = CW + 1;

  logic [CW-1:0] xfer_q, chunk_q;
  logic [NW-1:0] xfer_nxt, chunk_nxt;

  always_comb begin
    xfer_nxt   = {1'b0, xfer_q} + NW'(step_i);
    chunk_nxt  = {1'b0, chunk_q} + NW'(step_i);
    rollover_o = chunk_nxt >= {1'b0, chunk_i};
    last_o     = xfer_nxt >= {1'b0, total_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q  <= '0;
      chunk_q <= '0;
    end else if (load_i) begin
      xfer_q  <= '0;
      chunk_q <= '0;
    end else if (fire_i) begin
      xfer_q  <= xfer_nxt[CW-1:0];
      chunk_q <= rollover_o ? '0 : chunk_nxt[CW-1:0];
    end
  end

endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen
  import dma_seq_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic [1:0]        mode_i,
  input  logic              fire_i,
  input  logic              rollover_i,
  input  logic              last_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     base_o,
  output logic [1:0]        mode_o
);

  // Address of the beat that follows the current one.
  function automatic logic [AW-1:0] follow(input logic [1:0] m, input logic [AW-1:0] cur,
                                           input logic [AW-1:0] base,
                                           input logic [STEP_W-1:0] step, input logic roll);
    case (m)
      MODE_HOLD:       return base;
      MODE_CHUNK_WRAP: return roll ? base : cur + AW'(step);
      default:         return cur + AW'(step);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      base_o <= '0;
      mode_o <= '0;
    end else if (load_i) begin
      addr_o <= start_addr_i;
      base_o <= start_addr_i;
      mode_o <= mode_i;
    end else if (fire_i && !last_i) begin
      addr_o <= follow(mode_o, addr_o, base_o, step_i, rollover_i);
    end
  end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_start_i,
  input  logic [AW-1:0] dst_start_i,
  input  logic [CW-1:0] total_bytes_i,
  input  logic [CW-1:0] chunk_bytes_i,
  input  logic [1:0]    width_code_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic          beat_ok_i,
  output logic          busy_o,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          done_o,
  output logic          cfg_err_o
);

  localparam int NSIDE = 2;

  logic              busy_q, done_q, err_q;
  logic [1:0]        width_q;
  logic [CW-1:0]     total_q, chunk_q;
  logic              accept, go_start, mode_bad, size_bad;
  logic              beat_fire, last_beat, chunk_rollover;
  logic [STEP_W-1:0] step_bytes;

  logic [NSIDE-1:0][AW-1:0] side_start_in, side_addr, side_base;
  logic [NSIDE-1:0][1:0]    side_mode_in, side_mode;

  seq_cfg_check #(.CW(CW)) u_cfg (
    .src_mode_i  (src_mode_i),
    .dst_mode_i  (dst_mode_i),
    .width_code_i(width_code_i),
    .total_i     (total_bytes_i),
    .chunk_i     (chunk_bytes_i),
    .mode_bad_o  (mode_bad),
    .size_bad_o  (size_bad)
  );

  assign accept     = start_i && !busy_q;
  assign go_start   = accept && !mode_bad && !size_bad;
  assign beat_fire  = beat_ok_i && busy_q;
  assign step_bytes = beat_bytes(width_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      width_q <= '0;
      total_q <= '0;
      chunk_q <= '0;
    end else begin
      done_q <= beat_fire && last_beat;
      err_q  <= accept && (mode_bad || size_bad);
      if (go_start) begin
        busy_q  <= 1'b1;
        width_q <= width_code_i;
        total_q <= total_bytes_i;
        chunk_q <= chunk_bytes_i;
      end else if (beat_fire && last_beat) begin
        busy_q <= 1'b0;
      end
    end
  end

  seq_byte_counter #(.CW(CW)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (go_start),
    .fire_i    (beat_fire),
    .step_i    (step_bytes),
    .total_i   (total_q),
    .chunk_i   (chunk_q),
    .rollover_o(chunk_rollover),
    .last_o    (last_beat)
  );

  assign side_start_in[0] = src_start_i;
  assign side_start_in[1] = dst_start_i;
  assign side_mode_in[0]  = src_mode_i;
  assign side_mode_in[1]  = dst_mode_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    seq_addr_gen #(.AW(AW)) u_gen (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (go_start),
      .start_addr_i(side_start_in[s]),
      .mode_i      (side_mode_in[s]),
      .fire_i      (beat_fire),
      .rollover_i  (chunk_rollover),
      .last_i      (last_beat),
      .step_i      (step_bytes),
      .addr_o      (side_addr[s]),
      .base_o      (side_base[s]),
      .mode_o      (side_mode[s])
    );
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign cfg_err_o  = err_q;
  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int AW = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AW-1:0]        src_start_i,
  input logic [AW-1:0]        dst_start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 cfg_err_o,
  input logic                 go_start,
  input logic                 beat_fire,
  input logic                 last_beat,
  input logic                 chunk_rollover,
  input logic [2:0]           step_bytes,
  input logic [1:0][1:0]      side_mode,
  input logic [1:0][AW-1:0]   side_base,
  input logic [1:0][AW-1:0]   side_addr
);

  p_first_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_start |=> side_addr[0] == $past(src_start_i));

  p_first_dst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_start |=> side_addr[1] == $past(dst_start_i));

  p_err_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(beat_fire && last_beat) |=> busy_o);

  for (genvar s = 0; s < 2; s++) begin : g_side
    p_fixed_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && side_mode[s] == 2'd0 |-> side_addr[s] == side_base[s]);

    p_wrap_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      beat_fire && !last_beat && chunk_rollover && side_mode[s] == 2'd1
      |=> side_addr[s] == $past(side_base[s]));

    p_linear_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      beat_fire && !last_beat && side_mode[s] == 2'd2
      |=> side_addr[s] == $past(side_addr[s]) + AW'($past(step_bytes)));

    p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !beat_fire && !go_start |=> $stable(side_addr[s]));
  end

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_start_i   (src_start_i),
  .dst_start_i   (dst_start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .cfg_err_o     (cfg_err_o),
  .go_start      (go_start),
  .beat_fire     (beat_fire),
  .last_beat     (last_beat),
  .chunk_rollover(chunk_rollover),
  .step_bytes    (step_bytes),
  .side_mode     (side_mode),
  .side_base     (side_base),
  .side_addr     (side_addr)
);

// File: tb/dma_addr_seq_bench.sv
module dma_addr_seq_bench;

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [1:0]  wc;
    logic [31:0] total;
    logic [31:0] chunk;
    logic [63:0] sb;
    logic [63:0] db;
    logic        stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 2'd2, 32'd16, 32'd8, 64'h0000_0000_1000_0000, 64'h0000_0000_2000_0040, 1'b0},
    '{2'd1, 2'd2, 2'd1, 32'd12, 32'd4, 64'h0000_0003_0000_0100, 64'h0000_0000_4000_0000, 1'b1},
    '{2'd0, 2'd1, 2'd0, 32'd10, 32'd4, 64'h0000_0000_0000_0777, 64'h0000_0000_0000_0200, 1'b0},
    '{2'd1, 2'd1, 2'd2, 32'd20, 32'd8, 64'h0000_0000_5000_0000, 64'h0000_0000_6000_0010, 1'b1},
    '{2'd2, 2'd2, 2'd2, 32'd8,  32'd4, 64'h0000_0000_FFFF_FFFC, 64'h0000_0001_FFFF_FFFC, 1'b0},
    '{2'd1, 2'd0, 2'd2, 32'd4,  32'd4, 64'h0000_0000_0000_0800, 64'h0000_0000_0000_0900, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] src_start = '0, dst_start = '0;
  logic [31:0] total = '0, chunk = '0;
  logic [1:0]  wcode = '0, smode = '0, dmode = '0;
  logic        beat_ok = 1'b0;
  logic        busy, done, cerr;
  logic [63:0] src_addr, dst_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dma_addr_seq u_dma_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_start_i(src_start), .dst_start_i(dst_start),
    .total_bytes_i(total), .chunk_bytes_i(chunk), .width_code_i(wcode),
    .src_mode_i(smode), .dst_mode_i(dmode), .beat_ok_i(beat_ok),
    .busy_o(busy), .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .done_o(done), .cfg_err_o(cerr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Restated from the requirements: hold, chunk-wrap and run modes (R3, R4, R5).
  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] base,
                                        input int off, input int chunk_sz);
    case (m)
      2'd0:    return base;
      2'd1:    return base + 64'(off % chunk_sz);
      default: return base + 64'(off);
    endcase
  endfunction

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'd0:    return "R3";
      2'd1:    return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int wbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4; // R7
  endfunction

  task automatic run_vec(input vec_t v);
    int w, nb;
    logic [63:0] hold_s, hold_d;
    w  = wbytes(v.wc);
    nb = int'(v.total) / w;
    smode = v.sm; dmode = v.dm; wcode = v.wc;
    total = v.total; chunk = v.chunk; src_start = v.sb; dst_start = v.db;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Junk configuration; must be ignored while busy (R10).
    src_start = 64'hDEAD_BEEF_0000_0000; dst_start = 64'hBAD0_0000_0000_0000;
    smode = 2'd3; dmode = 2'd3;
    chk("R2 busy", 64'(busy), 64'd1);
    for (int i = 0; i < nb; i++) begin
      int off;
      off = i * w;
      chk(i == 0 ? "R2 src" : $sformatf("%s R7 src", tag(v.sm)), src_addr,
          model(v.sm, v.sb, off, int'(v.chunk)));
      chk(i == 0 ? "R2 dst" : $sformatf("R6 %s R7 dst", tag(v.dm)), dst_addr,
          model(v.dm, v.db, off, int'(v.chunk)));
      if (v.stall && i == 1) begin
        hold_s = src_addr; hold_d = dst_addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R9 stall src", src_addr, hold_s);
        chk("R9 stall dst", dst_addr, hold_d);
        chk("R10 no err", 64'(cerr), 64'd0);
      end
      beat_ok = 1'b1;
      @(negedge clk);
      beat_ok = 1'b0;
      if (i < nb - 1) chk("R8 busy mid", 64'(busy), 64'd1);
    end
    chk("R8 done", 64'(done), 64'd1);
    chk("R8 idle", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R8 done pulse", 64'(done), 64'd0);
  endtask

  task automatic try_bad(input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] wc,
                         input logic [31:0] tot, input logic [31:0] chk_sz);
    smode = sm; dmode = dm; wcode = wc; total = tot; chunk = chk_sz;
    src_start = 64'h1234; dst_start = 64'h5678;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 err", 64'(cerr), 64'd1);
    chk("R1 busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R1 err pulse", 64'(cerr), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 err", 64'(cerr), 64'd0);
    chk("R11 src", src_addr, 64'd0);
    chk("R11 dst", dst_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k]);
      @(negedge clk);
    end

    // Idle beats must not move the addresses (R9).
    begin
      logic [63:0] s0, d0;
      s0 = src_addr; d0 = dst_addr;
      beat_ok = 1'b1;
      repeat (3) @(negedge clk);
      beat_ok = 1'b0;
      chk("R9 idle src", src_addr, s0);
      chk("R9 idle dst", dst_addr, d0);
      chk("R9 idle done", 64'(done), 64'd0);
    end

    try_bad(2'd3, 2'd0, 2'd2, 32'd8, 32'd4);
    try_bad(2'd0, 2'd3, 2'd2, 32'd8, 32'd4);
    try_bad(2'd1, 2'd2, 2'd3, 32'd8, 32'd4);
    try_bad(2'd1, 2'd2, 2'd2, 32'd0, 32'd4);
    try_bad(2'd1, 2'd2, 2'd2, 32'd8, 32'd0);

    // A valid run after errors still works.
    run_vec(VECS[2]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule